// File: doc/BRIEF.md
# Multi-Source Reset Controller

This block merges every reset request of a small controller subsystem into a single internal system reset. It watches five sources:

- an external active-low reset pin, already synchronized to the system clock;
- a missing-clock timeout pulse;
- a comparator output qualified by the comparator's own enable;
- a watchdog timeout pulse;
- a memory-access checker, built into the block, that flags out-of-range or security-blocked accesses.

When any source fires, the system reset asserts on the next clock edge. It stays asserted until sixteen clean cycles have passed after the last source went quiet.

A status byte tells software which source caused the most recent reset. Each source owns one flag bit at a fixed position. Two of those bits also act as write-one enables for their sources: the missing-clock source and the comparator source. Internal sources never drive the external pin, because the block has no output toward it. A prescaler produces a watchdog clock enable at one twelfth of the system clock. It restarts with every reset.

Top module: `rst_hub`

## Requirements
- R1: While the block's power-on reset `rst_n` is low, `sys_rst_n` is 0 and the status byte reads 0. After `rst_n` rises, `sys_rst_n` stays 0 for 16 more cycles.
- R2: A low level on `ext_rst_n` asserts `sys_rst_n` low after the next clock edge, and sets status bit 0 as the only flag.
- R3: A `mclk_timeout` pulse causes a reset only while the missing-clock enable is set. Writing status bit 2 as 1 sets that enable and writing it as 0 clears it. Status bit 2 reads 1 after a missing-clock reset.
- R4: The comparator source fires when `cmp_out` is 0, `cmp_on` is 1 and the enable in status bit 5 is set; it then sets status bit 5. With `cmp_on` at 0 it never causes a reset.
- R5: A `wdt_timeout` pulse always causes a reset and sets status bit 3.
- R6: Valid accesses with an address above 0x3DFF cause a reset and set status bit 6. This covers a data read (`mem_kind` 00 or 11), an instruction fetch (`mem_kind` 10), and a write or erase (`mem_kind` 01) with `mem_wr_en` set. An access at 0x3DFF or below, and a write with `mem_wr_en` clear, cause no reset.
- R7: A valid access with `mem_locked` set causes a reset and sets status bit 6, whatever its address.
- R8: Each new reset clears all flags and sets only the winner. Among sources firing on the same cycle, the winner is chosen in this order: pin, missing clock, comparator, watchdog, memory error.
- R9: `sys_rst_n` stays 0 for exactly 16 cycles after the last cycle on which any source was active. A source held active extends the reset.
- R10: Every reset clears both source enables. Writes made while the reset is asserted are ignored. Bits 1, 4 and 7 of the status byte always read 0.
- R11: `wdt_tick` is 0 while the reset is asserted. It first pulses on the 12th cycle after release, then once every 12 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on reset of this block, synchronous, active low |
| ext_rst_n | input | 1 | Synchronized external reset pin, active low |
| mclk_timeout | input | 1 | Missing-clock one-shot timeout pulse |
| cmp_out | input | 1 | Comparator result, 0 when non-inverting input is below inverting input |
| cmp_on | input | 1 | Comparator powered and enabled |
| wdt_timeout | input | 1 | Watchdog timeout pulse |
| mem_valid | input | 1 | Memory access request present this cycle |
| mem_kind | input | 2 | 00 data read, 01 write/erase, 10 instruction fetch, 11 read |
| mem_wr_en | input | 1 | Program-memory write enable for write/erase requests |
| mem_addr | input | ADDR_W | Access address |
| mem_locked | input | 1 | Access blocked by the security setting |
| reg_wr | input | 1 | Status byte write strobe |
| reg_wdata | input | REG_W | Status byte write data |
| reg_rdata | output | REG_W | Status byte read data (cause flags) |
| sys_rst_n | output | 1 | Internal system reset, active low |
| wdt_tick | output | 1 | Watchdog count enable, one per WDT_DIV cycles |

## Verification
The bench targets the address boundary and checks that 0x3DFF is accepted while 0x3E00 is not. A checker off by one would reset on the last legal word or let the first illegal one pass. Write requests with the enable clear must pass even at 0xFFFF; a design that ignored the write enable would reset there. Several sources fire together to expose a wrong priority order or a status byte holding more than one flag. The bench also checks three more things: that enables vanish after a reset and that writes during reset are dropped, so a design that kept stale enables would fire on a later pulse; the exact reset length, so that any counter off by one stands out; and that the watchdog prescaler restarts on every release.

// File: rtl/rst_hub_pkg.sv
// Shared definitions for the reset controller: source indices, status bit
// positions and memory access kinds. Assumes a status byte of at least 7 bits.
package rst_hub_pkg;

    localparam int NUM_SRC = 5;

    // Source index doubles as priority: a lower index wins.
    typedef enum logic [2:0] {
        SRC_PIN  = 3'd0,
        SRC_MCLK = 3'd1,
        SRC_CMP  = 3'd2,
        SRC_WDT  = 3'd3,
        SRC_MEM  = 3'd4
    } src_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_FETCH = 2'b10,
        ACC_ALT   = 2'b11
    } acc_e;

    // Status byte position of each source's cause flag.
    function automatic int flag_pos(input int src);
        case (src)
            0:       return 0;
            1:       return 2;
            2:       return 5;
            3:       return 3;
            default: return 6;
        endcase
    endfunction

endpackage

// File: rtl/rst_mem_guard.sv
// Memory access checker: flags accesses above the user code limit and
// accesses blocked by security. Assumes requests are only meaningful while
// the system is out of reset (active high).
module rst_mem_guard
    import rst_hub_pkg::*;
#(
    parameter int          ADDR_W     = 16,
    parameter logic [15:0] CODE_LIMIT = 16'h3DFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              valid,
    input  logic [1:0]        kind,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              locked,
    output logic              err
);

    localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(CODE_LIMIT);

    logic above;
    logic is_write;

    // Classify the request and decide whether it is illegal.
    always_comb begin
        above    = (addr > LIMIT);
        is_write = (kind == ACC_WRITE);
        err      = active && valid && (locked || (above && (!is_write || wr_en)));
    end

    AST_LEGAL_ACCESS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !locked && (addr <= LIMIT)) |-> !err); // R6

endmodule

// File: rtl/rst_cause_arb.sv
// Fixed-priority arbiter over reset requests: index 0 has highest priority.
// Produces a one-hot grant and an any-request flag. Purely combinational.
module rst_cause_arb #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    output logic [N-1:0] grant,
    output logic         any
);

    logic [N:0] seen;

    assign seen[0] = 1'b0;

    // Ripple chain: each stage is granted only if no higher stage requested.
    for (genvar i = 0; i < N; i++) begin : g_stage
        assign grant[i]  = req[i] && !seen[i];
        assign seen[i+1] = seen[i] || req[i];
    end

    assign any = seen[N];

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R8
    AST_PIN_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        req[0] |-> (grant == N'(1))); // R8

endmodule

// File: rtl/rst_stretch.sv
// Reset stretcher: asserts the internal reset as soon as a request is seen
// and releases it HOLD_CYCLES cycles after the last request cycle. The block's
// own power-on reset counts as a request.
module rst_stretch #(
    parameter int HOLD_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic in_rst
);

    localparam int CNT_W = $clog2(HOLD_CYCLES + 1);
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(HOLD_CYCLES - 1);
    localparam logic [CNT_W:0]   HOLD_V = (CNT_W+1)'(HOLD_CYCLES);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   quiet;

    // Reload on any request, count down while quiet, release at zero.
    always_ff @(posedge clk) begin
        if (!rst_n || req) begin
            in_rst <= 1'b1;
            cnt    <= RELOAD;
        end else if (in_rst) begin
            if (cnt == '0) begin
                in_rst <= 1'b0;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    // Independent count of quiet reset cycles, used only to check the length.
    always_ff @(posedge clk) begin
        if (!rst_n || req || !in_rst) begin
            quiet <= '0;
        end else if (quiet != HOLD_V) begin
            quiet <= quiet + 1'b1;
        end
    end

    AST_HOLD_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_rst) |-> (quiet == HOLD_V)); // R9
    AST_REQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> in_rst); // R2

endmodule

// File: rtl/rst_wdt_prescale.sv
// Watchdog clock-enable prescaler: one tick every DIV cycles while out of
// reset. The count restarts from zero while hold is high.
module rst_wdt_prescale #(
    parameter int DIV = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    output logic tick
);

    localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [DW-1:0] LAST = DW'(DIV - 1);

    logic [DW-1:0] div_q;

    // Free-running modulo-DIV counter, cleared by any reset.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            div_q <= '0;
        end else if (div_q == LAST) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    assign tick = !hold && (div_q == LAST);

    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R11

endmodule

// File: rtl/rst_hub.sv
// Multi-source reset controller top. Gathers the pin, missing-clock,
// comparator, watchdog and memory-error requests, arbitrates the cause,
// stretches the system reset and keeps the cause flags and source enables.
// Assumes ext_rst_n is already synchronized to clk and has no output path.
module rst_hub
    import rst_hub_pkg::*;
#(
    parameter int          ADDR_W      = 16,
    parameter logic [15:0] CODE_LIMIT  = 16'h3DFF,
    parameter int          REG_W       = 8,
    parameter int          HOLD_CYCLES = 16,
    parameter int          WDT_DIV     = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_rst_n,
    input  logic              mclk_timeout,
    input  logic              cmp_out,
    input  logic              cmp_on,
    input  logic              wdt_timeout,
    input  logic              mem_valid,
    input  logic [1:0]        mem_kind,
    input  logic              mem_wr_en,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_locked,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              sys_rst_n,
    output logic              wdt_tick
);

    localparam int MCLK_POS = flag_pos(int'(SRC_MCLK));
    localparam int CMP_POS  = flag_pos(int'(SRC_CMP));

    logic [NUM_SRC-1:0] req;
    logic [NUM_SRC-1:0] grant;
    logic               any_req;
    logic               in_rst;
    logic               mem_err;
    logic               onset;
    logic               mclk_en;
    logic               cmp_en;
    logic [REG_W-1:0]   flags;
    logic [REG_W-1:0]   onset_flags;

    rst_mem_guard #(
        .ADDR_W     (ADDR_W),
        .CODE_LIMIT (CODE_LIMIT)
    ) u_guard (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (!in_rst),
        .valid  (mem_valid),
        .kind   (mem_kind),
        .wr_en  (mem_wr_en),
        .addr   (mem_addr),
        .locked (mem_locked),
        .err    (mem_err)
    );

    // Qualify each raw source into its request line.
    always_comb begin
        req               = '0;
        req[int'(SRC_PIN)]  = !ext_rst_n;
        req[int'(SRC_MCLK)] = mclk_timeout && mclk_en;
        req[int'(SRC_CMP)]  = cmp_on && cmp_en && !cmp_out;
        req[int'(SRC_WDT)]  = wdt_timeout;
        req[int'(SRC_MEM)]  = mem_err;
    end

    rst_cause_arb #(
        .N (NUM_SRC)
    ) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req),
        .grant (grant),
        .any   (any_req)
    );

    rst_stretch #(
        .HOLD_CYCLES (HOLD_CYCLES)
    ) u_stretch (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (any_req),
        .in_rst (in_rst)
    );

    rst_wdt_prescale #(
        .DIV (WDT_DIV)
    ) u_presc (
        .clk  (clk),
        .rst_n(rst_n),
        .hold (in_rst),
        .tick (wdt_tick)
    );

    assign onset = any_req && !in_rst;

    // Map the one-hot grant onto the status byte positions.
    always_comb begin
        onset_flags = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (grant[i]) begin
                onset_flags[flag_pos(i)] = 1'b1;
            end
        end
    end

    // Cause flags: replaced with the winner at the start of each new reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
        end else if (onset) begin
            flags <= onset_flags;
        end
    end

    // Source enables: cleared by every reset, written only outside reset.
    always_ff @(posedge clk) begin
        if (!rst_n || in_rst) begin
            mclk_en <= 1'b0;
            cmp_en  <= 1'b0;
        end else if (reg_wr) begin
            mclk_en <= reg_wdata[MCLK_POS];
            cmp_en  <= reg_wdata[CMP_POS];
        end
    end

    assign reg_rdata = flags;
    assign sys_rst_n = !in_rst;

    AST_REQ_ASSERTS: assert property (@(posedge clk) disable iff (!rst_n)
        any_req |=> !sys_rst_n); // R2
    AST_FLAGS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(reg_rdata)); // R8
    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !onset |=> $stable(reg_rdata)); // R8
    AST_EN_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        !sys_rst_n |=> (!mclk_en && !cmp_en)); // R10
    AST_TICK_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sys_rst_n) |-> !wdt_tick); // R11

endmodule

// File: tb/rst_hub_tb.sv
// Scoreboard bench: driver tasks push expected values, the check task pops
// and compares them against sampled outputs at the falling clock edge.
module rst_hub_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ext_rst_n, mclk_timeout, cmp_out, cmp_on, wdt_timeout;
    logic        mem_valid, mem_wr_en, mem_locked, reg_wr;
    logic [1:0]  mem_kind;
    logic [15:0] mem_addr;
    logic [7:0]  reg_wdata, reg_rdata;
    logic        sys_rst_n, wdt_tick;

    typedef struct {
        string tag;
        int    exp;
    } item_t;

    item_t sbq[$];
    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    rst_hub u_dut (
        .clk(clk), .rst_n(rst_n), .ext_rst_n(ext_rst_n),
        .mclk_timeout(mclk_timeout), .cmp_out(cmp_out), .cmp_on(cmp_on),
        .wdt_timeout(wdt_timeout), .mem_valid(mem_valid), .mem_kind(mem_kind),
        .mem_wr_en(mem_wr_en), .mem_addr(mem_addr), .mem_locked(mem_locked),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sys_rst_n(sys_rst_n), .wdt_tick(wdt_tick)
    );

    task automatic push(input string tag, input int exp);
        item_t it;
        it.tag = tag;
        it.exp = exp;
        sbq.push_back(it);
    endtask

    task automatic check(input int act);
        item_t it;
        it = sbq.pop_front();
        n_checks++;
        if (act != it.exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", it.tag, act, it.exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic low_run(output int len, output int ticks);
        len = 0;
        ticks = 0;
        while (!sys_rst_n && len < 2000) begin
            len++;
            if (wdt_tick) ticks++;
            @(negedge clk);
        end
    endtask

    task automatic reg_write(input logic [7:0] v);
        reg_wr = 1'b1;
        reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic pulse_mclk();
        mclk_timeout = 1'b1;
        @(negedge clk);
        mclk_timeout = 1'b0;
    endtask

    task automatic pulse_wdt();
        wdt_timeout = 1'b1;
        @(negedge clk);
        wdt_timeout = 1'b0;
    endtask

    task automatic mem_access(input logic [1:0] k, input logic we,
                              input logic [15:0] a, input logic lk);
        mem_valid = 1'b1;
        mem_kind = k;
        mem_wr_en = we;
        mem_addr = a;
        mem_locked = lk;
        @(negedge clk);
        mem_valid = 1'b0;
        mem_wr_en = 1'b0;
        mem_locked = 1'b0;
    endtask

    // Called on the sample right after the edge that saw the request.
    task automatic expect_reset(input string tag, input int exp_len, input int exp_flags);
        int len, ticks;
        push({tag, " reset asserted"}, 0);
        check(int'(sys_rst_n));
        low_run(len, ticks);
        push({tag, " reset length"}, exp_len);
        check(len);
        push({tag, " no tick in reset"}, 0);
        check(ticks);
        push({tag, " flags"}, exp_flags);
        check(int'(reg_rdata));
    endtask

    task automatic expect_none(input string tag, input int exp_flags);
        push({tag, " no reset now"}, 1);
        check(int'(sys_rst_n));
        cyc(3);
        push({tag, " no reset later"}, 1);
        check(int'(sys_rst_n));
        push({tag, " flags kept"}, exp_flags);
        check(int'(reg_rdata));
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        #(200000 * 4);
        n_fail++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int len, ticks, n;
        rst_n = 1'b0; ext_rst_n = 1'b1; mclk_timeout = 1'b0; cmp_out = 1'b1;
        cmp_on = 1'b1; wdt_timeout = 1'b0; mem_valid = 1'b0; mem_kind = 2'b00;
        mem_wr_en = 1'b0; mem_addr = '0; mem_locked = 1'b0; reg_wr = 1'b0;
        reg_wdata = '0;
        cyc(3);
        // R1: power-on reset state
        push("R1 por holds reset", 0);
        check(int'(sys_rst_n));
        push("R1 por flags zero", 0);
        check(int'(reg_rdata));
        rst_n = 1'b1;
        expect_reset("R1 por release", 16, 0);

        // R11: prescaler timing after release
        n = 1;
        while (!wdt_tick && n < 100) begin
            @(negedge clk);
            n++;
        end
        push("R11 first tick cycle", 12);
        check(n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!wdt_tick && n < 100);
        push("R11 tick period", 12);
        check(n);

        // R3: missing clock disabled by default, enable, then disable by 0
        pulse_mclk();
        expect_none("R3 mclk not enabled", 0);
        reg_write(8'h24);
        pulse_mclk();
        expect_reset("R3 mclk enabled", 16, 4);
        pulse_mclk();
        expect_none("R10 enable cleared by reset", 4);
        reg_write(8'h04);
        reg_write(8'h00);
        pulse_mclk();
        expect_none("R3 mclk disabled by write 0", 4);

        // R4: comparator gated by its own enable
        reg_write(8'h20);
        cmp_on = 1'b0;
        cmp_out = 1'b0;
        cyc(1);
        expect_none("R4 comparator off", 4);
        cmp_out = 1'b1;
        cmp_on = 1'b1;
        cyc(1);
        expect_none("R4 comparator high", 4);
        cmp_out = 1'b0;
        @(negedge clk);
        cmp_out = 1'b1;
        expect_reset("R4 comparator low", 16, 32);

        // R5: watchdog
        pulse_wdt();
        expect_reset("R5 watchdog", 16, 8);

        // R6: address limit and write-enable qualification
        mem_access(2'b00, 1'b0, 16'h3DFF, 1'b0);
        expect_none("R6 read at limit", 8);
        mem_access(2'b10, 1'b0, 16'h3DFF, 1'b0);
        expect_none("R6 fetch at limit", 8);
        mem_access(2'b01, 1'b0, 16'hFFFF, 1'b0);
        expect_none("R6 write without enable", 8);
        mem_access(2'b00, 1'b0, 16'h3E00, 1'b0);
        expect_reset("R6 read above", 16, 64);
        pulse_wdt();
        expect_reset("R5 watchdog again", 16, 8);
        mem_access(2'b01, 1'b1, 16'h3E00, 1'b0);
        expect_reset("R6 write above", 16, 64);
        mem_access(2'b10, 1'b0, 16'h4000, 1'b0);
        expect_reset("R6 fetch above", 16, 64);
        pulse_wdt();
        expect_reset("R5 watchdog third", 16, 8);

        // R7: security block
        mem_access(2'b00, 1'b0, 16'h0000, 1'b1);
        expect_reset("R7 locked access", 16, 64);

        // R8: priority when sources coincide
        reg_write(8'h24);
        ext_rst_n = 1'b0; mclk_timeout = 1'b1; wdt_timeout = 1'b1;
        cmp_out = 1'b0; mem_valid = 1'b1; mem_kind = 2'b00; mem_addr = 16'h3E00;
        @(negedge clk);
        ext_rst_n = 1'b1; mclk_timeout = 1'b0; wdt_timeout = 1'b0;
        cmp_out = 1'b1; mem_valid = 1'b0;
        expect_reset("R8 pin wins", 16, 1);
        reg_write(8'h24);
        mclk_timeout = 1'b1; wdt_timeout = 1'b1; cmp_out = 1'b0;
        mem_valid = 1'b1; mem_addr = 16'h3E00;
        @(negedge clk);
        mclk_timeout = 1'b0; wdt_timeout = 1'b0; cmp_out = 1'b1; mem_valid = 1'b0;
        expect_reset("R8 mclk wins", 16, 4);
        reg_write(8'h20);
        cmp_out = 1'b0; wdt_timeout = 1'b1;
        mem_valid = 1'b1; mem_addr = 16'h3E00;
        @(negedge clk);
        cmp_out = 1'b1; wdt_timeout = 1'b0; mem_valid = 1'b0;
        expect_reset("R8 comparator wins", 16, 32);
        wdt_timeout = 1'b1; mem_valid = 1'b1; mem_addr = 16'h3E00;
        @(negedge clk);
        wdt_timeout = 1'b0; mem_valid = 1'b0;
        expect_reset("R8 watchdog wins", 16, 8);

        // R2 and R9: pin held low extends the reset
        ext_rst_n = 1'b0;
        cyc(1);
        push("R2 pin asserts next cycle", 0);
        check(int'(sys_rst_n));
        cyc(5);
        push("R9 still in reset while pin low", 0);
        check(int'(sys_rst_n));
        ext_rst_n = 1'b1;
        expect_reset("R9 release after pin", 16, 1);

        // R10: write during reset dropped, unused bits read 0
        pulse_wdt();
        reg_write(8'hFF);
        low_run(len, ticks);
        push("R10 reset length around write", 15);
        check(len);
        pulse_mclk();
        expect_none("R10 write in reset ignored", 8);
        reg_write(8'hFF);
        push("R10 unused bits read zero", 8);
        check(int'(reg_rdata));
        pulse_mclk();
        expect_reset("R3 enable via full write", 16, 4);

        summary();
        $finish;
    end

endmodule